// File: doc/BRIEF.md
# AXI-Lite Transaction Timeout Guard

This block sits between an AXI-Lite master and the downstream slave path and watches every transaction for a reply. The write side and the read side each have their own cycle counter. A transaction that the slave finishes in time passes through untouched. If no response reaches the master within a fixed number of cycles, the block ends the transaction itself with an error response, so the master never waits forever on a dead or missing slave.

On a timeout the block takes over the master-side handshake. Any address or data beat the slave has not yet accepted is now accepted by the block, and that beat is no longer offered to the slave. The block then holds its own error response until the master takes it. A write ends with SLVERR. A read ends with SLVERR and data of all ones. If the slave had already taken the whole request, its reply may still arrive later. The block accepts that late reply on the slave side and drops it, so the master never sees a second response for one transaction.

Top module: `axil_tmo_guard`

## Requirements
- R1: A write that the slave answers within the window passes through. The slave sees the master's address, data and strobes, and the master receives the slave's write response (OKAY = 2'b00).
- R2: A read that the slave answers within the window returns the slave's read data and response to the master unchanged.
- R3: Cycle 0 is the first cycle in which the master holds a request valid. If a write has no response handshake by cycle TMO_CYCLES-1, the block returns bresp SLVERR (2'b10). When the slave took address and data in cycle 0, the error response is visible in cycle TMO_CYCLES.
- R4: A read that times out returns rresp SLVERR (2'b10) with read data of all ones.
- R5: If the slave never accepted the request, then on a timeout the block raises m_awready_o, m_wready_o or m_arready_o for each beat still outstanding. The error response follows one cycle later, in cycle TMO_CYCLES+1.
- R6: An error response stays valid, with the same response code, until the master handshakes it.
- R7: A slave response that arrives after its transaction has timed out is accepted toward the slave (ready high). It is never presented to the master.
- R8: After a timeout, later transactions on the same channel complete normally with OKAY.
- R9: The write and read channels time out independently. A stalled read does not delay or fail a write that is issued at the same time.
- R10: A response handshaken in cycle TMO_CYCLES-1 completes with the slave's OKAY. A slave response made ready one cycle later than that is replaced by the error response.
- R11: While rst_ni is low, m_bvalid_o, m_rvalid_o, s_awvalid_o, s_wvalid_o and s_arvalid_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| m_awvalid_i | input | 1 | Master write address valid |
| m_awready_o | output | 1 | Write address ready to master |
| m_awaddr_i | input | ADDR_W | Master write address |
| m_wvalid_i | input | 1 | Master write data valid |
| m_wready_o | output | 1 | Write data ready to master |
| m_wdata_i | input | DATA_W | Master write data |
| m_wstrb_i | input | DATA_W/8 | Master write strobes |
| m_bvalid_o | output | 1 | Write response valid to master |
| m_bready_i | input | 1 | Master write response ready |
| m_bresp_o | output | 2 | Write response code to master |
| m_arvalid_i | input | 1 | Master read address valid |
| m_arready_o | output | 1 | Read address ready to master |
| m_araddr_i | input | ADDR_W | Master read address |
| m_rvalid_o | output | 1 | Read data valid to master |
| m_rready_i | input | 1 | Master read data ready |
| m_rdata_o | output | DATA_W | Read data to master |
| m_rresp_o | output | 2 | Read response code to master |
| s_awvalid_o | output | 1 | Write address valid to slave |
| s_awready_i | input | 1 | Slave write address ready |
| s_awaddr_o | output | ADDR_W | Write address to slave |
| s_wvalid_o | output | 1 | Write data valid to slave |
| s_wready_i | input | 1 | Slave write data ready |
| s_wdata_o | output | DATA_W | Write data to slave |
| s_wstrb_o | output | DATA_W/8 | Write strobes to slave |
| s_bvalid_i | input | 1 | Slave write response valid |
| s_bready_o | output | 1 | Write response ready to slave |
| s_bresp_i | input | 2 | Slave write response code |
| s_arvalid_o | output | 1 | Read address valid to slave |
| s_arready_i | input | 1 | Slave read address ready |
| s_araddr_o | output | ADDR_W | Read address to slave |
| s_rvalid_i | input | 1 | Slave read data valid |
| s_rready_o | output | 1 | Read data ready to slave |
| s_rdata_i | input | DATA_W | Slave read data |
| s_rresp_i | input | 2 | Slave read response code |

## Verification
Transactions are driven against a slave model in several configurations. In one, the slave accepts at once and answers quickly. In another, it answers in the last cycle of the window or just one cycle after it. In a third, it answers well after the timeout, and in a fourth it never accepts the request at all. Measuring the response cycle separates an in-time pass-through from an error that appears in cycle TMO_CYCLES or TMO_CYCLES+1, and that cycle shows whether the block had to accept the request itself. After each transaction a quiet stretch of cycles would expose a late slave reply leaking to the master. Running a stalled read in parallel with a fast write separates channels with independent counters from a shared one.

// File: rtl/axil_tmo_pkg.sv
package axil_tmo_pkg;

  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_ERR  = 2'd2
  } tmo_state_e;

endpackage

// File: rtl/axil_tmo_counter.sv
module axil_tmo_counter #(
  parameter int LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic last_o
);

  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign last_o = (cnt_q == LAST);

  // restarts from zero whenever the channel is not waiting
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!run_i)      cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST) else $error("counter past limit"); // R3

endmodule

// File: rtl/axil_tmo_chan.sv
module axil_tmo_chan
  import axil_tmo_pkg::*;
#(
  parameter int NREQ  = 1,
  parameter int LIMIT = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NREQ-1:0] m_req_valid_i,
  output logic [NREQ-1:0] m_req_ready_o,
  output logic [NREQ-1:0] s_req_valid_o,
  input  logic [NREQ-1:0] s_req_ready_i,
  output logic            m_rsp_valid_o,
  input  logic            m_rsp_ready_i,
  input  logic            s_rsp_valid_i,
  output logic            s_rsp_ready_o,
  output logic            err_o
);

  tmo_state_e      state_q;
  logic [NREQ-1:0] done_q;
  logic [NREQ-1:0] req_hs;
  logic            owe_q;
  logic            in_err, pending, rsp_hs, run, at_last, enter_err, all_done;

  assign in_err = (state_q == ST_ERR);
  assign err_o  = in_err;

  // per request lane: forward to slave, or absorb once timed out
  for (genvar g = 0; g < NREQ; g++) begin : g_lane
    assign s_req_valid_o[g] = in_err ? 1'b0 : (m_req_valid_i[g] & ~done_q[g]);
    assign m_req_ready_o[g] = in_err ? ~done_q[g] : (s_req_ready_i[g] & ~done_q[g]);
  end

  assign req_hs   = m_req_valid_i & m_req_ready_o;
  assign all_done = &(done_q | req_hs);

  always_comb begin
    if (in_err) begin
      m_rsp_valid_o = &done_q;
      s_rsp_ready_o = owe_q;
    end else begin
      m_rsp_valid_o = s_rsp_valid_i & ~owe_q;
      s_rsp_ready_o = owe_q | m_rsp_ready_i;
    end
  end

  assign rsp_hs    = m_rsp_valid_o & m_rsp_ready_i;
  assign pending   = (state_q == ST_BUSY) | ((state_q == ST_IDLE) & (|m_req_valid_i));
  assign run       = ~in_err & pending & ~rsp_hs;
  assign enter_err = run & at_last;

  axil_tmo_counter #(.LIMIT(LIMIT)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .last_o (at_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= '0;
    end else if (rsp_hs) begin
      state_q <= ST_IDLE;
      done_q  <= '0;
    end else begin
      done_q <= done_q | req_hs;
      if (enter_err)    state_q <= ST_ERR;
      else if (pending) state_q <= ST_BUSY;
    end
  end

  // slave holds a full request: its eventual reply must be swallowed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                    owe_q <= 1'b0;
    else if (enter_err && all_done)                 owe_q <= 1'b1;
    else if (owe_q && s_rsp_valid_i && s_rsp_ready_o) owe_q <= 1'b0;
  end

  AST_RSP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_rsp_valid_o && !m_rsp_ready_i |=> m_rsp_valid_o) else $error("response dropped"); // R6
  AST_SINGLE_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_hs |=> !m_rsp_valid_o) else $error("second response"); // R7
  AST_ERR_NO_SLAVE_HS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_err |-> !(|(s_req_valid_o & s_req_ready_i))) else $error("slave took request in error"); // R5
  AST_ERR_AFTER_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_err) |-> $past(pending)) else $error("error without pending"); // R3

endmodule

// File: rtl/axil_tmo_guard.sv
module axil_tmo_guard
  import axil_tmo_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int TMO_CYCLES = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                m_awvalid_i,
  output logic                m_awready_o,
  input  logic [ADDR_W-1:0]   m_awaddr_i,
  input  logic                m_wvalid_i,
  output logic                m_wready_o,
  input  logic [DATA_W-1:0]   m_wdata_i,
  input  logic [DATA_W/8-1:0] m_wstrb_i,
  output logic                m_bvalid_o,
  input  logic                m_bready_i,
  output logic [1:0]          m_bresp_o,
  input  logic                m_arvalid_i,
  output logic                m_arready_o,
  input  logic [ADDR_W-1:0]   m_araddr_i,
  output logic                m_rvalid_o,
  input  logic                m_rready_i,
  output logic [DATA_W-1:0]   m_rdata_o,
  output logic [1:0]          m_rresp_o,
  output logic                s_awvalid_o,
  input  logic                s_awready_i,
  output logic [ADDR_W-1:0]   s_awaddr_o,
  output logic                s_wvalid_o,
  input  logic                s_wready_i,
  output logic [DATA_W-1:0]   s_wdata_o,
  output logic [DATA_W/8-1:0] s_wstrb_o,
  input  logic                s_bvalid_i,
  output logic                s_bready_o,
  input  logic [1:0]          s_bresp_i,
  output logic                s_arvalid_o,
  input  logic                s_arready_i,
  output logic [ADDR_W-1:0]   s_araddr_o,
  input  logic                s_rvalid_i,
  output logic                s_rready_o,
  input  logic [DATA_W-1:0]   s_rdata_i,
  input  logic [1:0]          s_rresp_i
);

  localparam int WR_LANES = 2;
  localparam int RD_LANES = 1;

  logic                wr_err, rd_err;
  logic [WR_LANES-1:0] wr_m_ready, wr_s_valid;
  logic [RD_LANES-1:0] rd_m_ready, rd_s_valid;

  // lane 0 = address, lane 1 = data
  axil_tmo_chan #(.NREQ(WR_LANES), .LIMIT(TMO_CYCLES)) u_wr (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .m_req_valid_i ({m_wvalid_i, m_awvalid_i}),
    .m_req_ready_o (wr_m_ready),
    .s_req_valid_o (wr_s_valid),
    .s_req_ready_i ({s_wready_i, s_awready_i}),
    .m_rsp_valid_o (m_bvalid_o),
    .m_rsp_ready_i (m_bready_i),
    .s_rsp_valid_i (s_bvalid_i),
    .s_rsp_ready_o (s_bready_o),
    .err_o         (wr_err)
  );

  axil_tmo_chan #(.NREQ(RD_LANES), .LIMIT(TMO_CYCLES)) u_rd (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .m_req_valid_i (m_arvalid_i),
    .m_req_ready_o (rd_m_ready),
    .s_req_valid_o (rd_s_valid),
    .s_req_ready_i (s_arready_i),
    .m_rsp_valid_o (m_rvalid_o),
    .m_rsp_ready_i (m_rready_i),
    .s_rsp_valid_i (s_rvalid_i),
    .s_rsp_ready_o (s_rready_o),
    .err_o         (rd_err)
  );

  assign m_awready_o = wr_m_ready[0];
  assign m_wready_o  = wr_m_ready[1];
  assign s_awvalid_o = wr_s_valid[0];
  assign s_wvalid_o  = wr_s_valid[1];
  assign m_arready_o = rd_m_ready[0];
  assign s_arvalid_o = rd_s_valid[0];

  assign s_awaddr_o = m_awaddr_i;
  assign s_wdata_o  = m_wdata_i;
  assign s_wstrb_o  = m_wstrb_i;
  assign s_araddr_o = m_araddr_i;

  assign m_bresp_o = wr_err ? RESP_SLVERR : s_bresp_i;
  assign m_rresp_o = rd_err ? RESP_SLVERR : s_rresp_i;
  assign m_rdata_o = rd_err ? {DATA_W{1'b1}} : s_rdata_i;

  AST_RD_ERR_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_rvalid_o && rd_err |-> (&m_rdata_o) && (m_rresp_o == RESP_SLVERR))
    else $error("bad read error beat"); // R4
  AST_WR_ERR_RESP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_bvalid_o && wr_err |-> m_bresp_o == RESP_SLVERR) else $error("bad write error"); // R3

endmodule

// File: tb/tb_axil_tmo_guard.sv
module tb_axil_tmo_guard;

  localparam int CLK_PERIOD = 10;
  localparam int TMO = 16;
  localparam int NV  = 14;

  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [31:0] data;
    logic [7:0]  lat;
    logic        acc;
    logic        err;
  } vec_t;

  // wr, addr, data, slave latency, slave accepts request, expect error
  localparam vec_t VECS [NV] = '{
    '{1'b1, 32'h0000_0100, 32'h1111_1111, 8'd0,   1'b1, 1'b0},  // R1
    '{1'b0, 32'h0000_0104, 32'h0,         8'd0,   1'b1, 1'b0},  // R2
    '{1'b1, 32'h0000_0108, 32'h2222_2222, 8'd14,  1'b1, 1'b0},  // R10
    '{1'b0, 32'h0000_010c, 32'h0,         8'd14,  1'b1, 1'b0},  // R10
    '{1'b1, 32'h0000_0200, 32'h3333_3333, 8'd255, 1'b0, 1'b1},  // R3 R5
    '{1'b1, 32'h0000_0204, 32'h4444_4444, 8'd3,   1'b1, 1'b0},  // R8
    '{1'b0, 32'h0000_0300, 32'h0,         8'd255, 1'b0, 1'b1},  // R4 R5
    '{1'b0, 32'h0000_0304, 32'h0,         8'd2,   1'b1, 1'b0},  // R8
    '{1'b1, 32'h0000_0400, 32'h5555_5555, 8'd15,  1'b1, 1'b1},  // R10 R7
    '{1'b1, 32'h0000_0404, 32'h6666_6666, 8'd20,  1'b1, 1'b1},  // R7
    '{1'b0, 32'h0000_0500, 32'h0,         8'd15,  1'b1, 1'b1},  // R10 R7
    '{1'b0, 32'h0000_0504, 32'h0,         8'd25,  1'b1, 1'b1},  // R7
    '{1'b1, 32'h0000_0600, 32'h7777_7777, 8'd1,   1'b1, 1'b0},  // R8
    '{1'b0, 32'h0000_0604, 32'h0,         8'd1,   1'b1, 1'b0}   // R8
  };

  logic clk, rst_ni;
  logic m_awvalid, m_awready, m_wvalid, m_wready, m_bvalid, m_bready;
  logic m_arvalid, m_arready, m_rvalid, m_rready;
  logic [31:0] m_awaddr, m_wdata, m_araddr, m_rdata;
  logic [3:0]  m_wstrb;
  logic [1:0]  m_bresp, m_rresp;
  logic s_awvalid, s_awready, s_wvalid, s_wready, s_bvalid, s_bready;
  logic s_arvalid, s_arready, s_rvalid, s_rready;
  logic [31:0] s_awaddr, s_wdata, s_araddr, s_rdata;
  logic [3:0]  s_wstrb;
  logic [1:0]  s_bresp, s_rresp;

  int n_chk, n_fail;

  // slave model controls (written by main flow only)
  logic acc_w, acc_r;
  int   lat_w, lat_r;
  int   flush_cnt;
  // slave model observations
  logic [31:0] seen_awaddr, seen_wdata;
  logic [3:0]  seen_wstrb;

  assign s_awready = acc_w;
  assign s_wready  = acc_w;
  assign s_arready = acc_r;

  axil_tmo_guard #(.ADDR_W(32), .DATA_W(32), .TMO_CYCLES(TMO)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .m_awvalid_i(m_awvalid), .m_awready_o(m_awready), .m_awaddr_i(m_awaddr),
    .m_wvalid_i(m_wvalid), .m_wready_o(m_wready), .m_wdata_i(m_wdata), .m_wstrb_i(m_wstrb),
    .m_bvalid_o(m_bvalid), .m_bready_i(m_bready), .m_bresp_o(m_bresp),
    .m_arvalid_i(m_arvalid), .m_arready_o(m_arready), .m_araddr_i(m_araddr),
    .m_rvalid_o(m_rvalid), .m_rready_i(m_rready), .m_rdata_o(m_rdata), .m_rresp_o(m_rresp),
    .s_awvalid_o(s_awvalid), .s_awready_i(s_awready), .s_awaddr_o(s_awaddr),
    .s_wvalid_o(s_wvalid), .s_wready_i(s_wready), .s_wdata_o(s_wdata), .s_wstrb_o(s_wstrb),
    .s_bvalid_i(s_bvalid), .s_bready_o(s_bready), .s_bresp_i(s_bresp),
    .s_arvalid_o(s_arvalid), .s_arready_i(s_arready), .s_araddr_o(s_araddr),
    .s_rvalid_i(s_rvalid), .s_rready_o(s_rready), .s_rdata_i(s_rdata), .s_rresp_i(s_rresp)
  );

  function automatic logic [31:0] rd_pat(input logic [31:0] a);
    return a ^ 32'hC0DE_0000;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  // slave model: samples at negedge, updates after posedge
  initial begin : slave
    logic aw_got, w_got, ar_got, aw_hs, w_hs, b_hs, ar_hs, r_hs;
    logic [31:0] ar_addr;
    int wcnt, rcnt, flush_seen;
    aw_got = 0; w_got = 0; ar_got = 0; wcnt = 0; rcnt = 0; flush_seen = 0;
    ar_addr = '0;
    s_bvalid = 0; s_bresp = 2'b00; s_rvalid = 0; s_rdata = '0; s_rresp = 2'b00;
    seen_awaddr = '0; seen_wdata = '0; seen_wstrb = '0;
    forever begin
      @(negedge clk);
      aw_hs = s_awvalid && s_awready;
      w_hs  = s_wvalid && s_wready;
      b_hs  = s_bvalid && s_bready;
      ar_hs = s_arvalid && s_arready;
      r_hs  = s_rvalid && s_rready;
      if (aw_hs) seen_awaddr = s_awaddr;
      if (w_hs) begin seen_wdata = s_wdata; seen_wstrb = s_wstrb; end
      if (ar_hs) ar_addr = s_araddr;
      @(posedge clk); #1;
      if (flush_cnt != flush_seen) begin
        flush_seen = flush_cnt;
        aw_got = 0; w_got = 0; ar_got = 0; wcnt = 0; rcnt = 0;
        s_bvalid = 0; s_rvalid = 0;
      end else begin
        if (aw_hs) aw_got = 1;
        if (w_hs)  w_got = 1;
        if (ar_hs) ar_got = 1;
        if (b_hs) begin
          s_bvalid = 0; aw_got = 0; w_got = 0; wcnt = 0;
        end else if (aw_got && w_got && !s_bvalid) begin
          if (wcnt == lat_w) begin s_bvalid = 1; s_bresp = 2'b00; end
          else wcnt++;
        end
        if (r_hs) begin
          s_rvalid = 0; ar_got = 0; rcnt = 0;
        end else if (ar_got && !s_rvalid) begin
          if (rcnt == lat_r) begin s_rvalid = 1; s_rresp = 2'b00; s_rdata = rd_pat(ar_addr); end
          else rcnt++;
        end
      end
    end
  end

  task automatic do_write(input logic [31:0] a, input logic [31:0] d, input int bdly,
                          output logic [1:0] resp, output int lat, output bit held);
    int cyc, bw;
    bit got, seen, hs_aw, hs_w, bv;
    @(posedge clk); #1;
    m_awaddr = a; m_wdata = d; m_wstrb = 4'hF;
    m_awvalid = 1; m_wvalid = 1; m_bready = (bdly == 0);
    cyc = 0; bw = 0; got = 0; seen = 0; held = 1; lat = -1; resp = 2'b11;
    while (!got) begin
      @(negedge clk);
      hs_aw = m_awvalid && m_awready;
      hs_w  = m_wvalid && m_wready;
      bv    = m_bvalid;
      if (seen && (!bv || m_bresp != resp)) held = 0;
      if (bv && !seen) begin seen = 1; lat = cyc; resp = m_bresp; end
      if (bv && m_bready) got = 1;
      @(posedge clk); #1;
      cyc++;
      if (hs_aw) m_awvalid = 0;
      if (hs_w)  m_wvalid = 0;
      if (got) m_bready = 0;
      else if (seen) begin bw++; if (bw >= bdly) m_bready = 1; end
    end
  endtask

  task automatic do_read(input logic [31:0] a, output logic [1:0] resp,
                         output logic [31:0] data, output int lat);
    int cyc;
    bit got, hs_ar;
    @(posedge clk); #1;
    m_araddr = a; m_arvalid = 1; m_rready = 1;
    cyc = 0; got = 0; lat = -1; resp = 2'b11; data = '0;
    while (!got) begin
      @(negedge clk);
      hs_ar = m_arvalid && m_arready;
      if (m_rvalid) begin got = 1; lat = cyc; resp = m_rresp; data = m_rdata; end
      @(posedge clk); #1;
      cyc++;
      if (hs_ar) m_arvalid = 0;
      if (got) m_rready = 0;
    end
  endtask

  // quiet window: no response may reach the master
  task automatic drain(output bit stray);
    stray = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (m_bvalid || m_rvalid) stray = 1;
    end
    @(posedge clk); #1;
    flush_cnt++;
    repeat (2) @(posedge clk);
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 50000);
    n_fail++;
    $display("FAIL watchdog: actual hung, expected run finished");
    summary();
    $finish;
  end

  initial begin : main
    logic [1:0] resp, resp2;
    logic [31:0] data;
    int lat, lat2, exp_lat;
    bit held, stray;
    n_chk = 0; n_fail = 0; flush_cnt = 0;
    acc_w = 1; acc_r = 1; lat_w = 0; lat_r = 0;
    m_awvalid = 0; m_wvalid = 0; m_bready = 0; m_arvalid = 0; m_rready = 0;
    m_awaddr = '0; m_wdata = '0; m_wstrb = '0; m_araddr = '0;
    rst_ni = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset state of the valid outputs
    chk(!m_bvalid && !m_rvalid, "R11", "master rsp valid in reset",
        {30'd0, m_bvalid, m_rvalid}, 32'd0);
    chk(!s_awvalid && !s_wvalid && !s_arvalid, "R11", "slave req valid in reset",
        {29'd0, s_awvalid, s_wvalid, s_arvalid}, 32'd0);
    @(posedge clk); #1;
    rst_ni = 1;
    repeat (2) @(posedge clk);

    for (int v = 0; v < NV; v++) begin
      acc_w = VECS[v].acc; acc_r = VECS[v].acc;
      lat_w = int'(VECS[v].lat); lat_r = int'(VECS[v].lat);
      exp_lat = VECS[v].err ? (VECS[v].acc ? TMO : TMO + 1) : 1 + int'(VECS[v].lat);
      if (VECS[v].wr) begin
        do_write(VECS[v].addr, VECS[v].data, 0, resp, lat, held);
        // R1 R3 R8 R10: response code
        chk(resp == (VECS[v].err ? 2'b10 : 2'b00), VECS[v].err ? "R3" : "R1",
            "write resp", {30'd0, resp}, {30'd0, VECS[v].err ? 2'b10 : 2'b00});
        chk(lat == exp_lat, VECS[v].err ? "R5" : "R10", "write resp cycle", lat, exp_lat);
        if (VECS[v].acc)
          chk(seen_awaddr == VECS[v].addr && seen_wdata == VECS[v].data && seen_wstrb == 4'hF,
              "R1", "slave saw write", seen_wdata, VECS[v].data);
      end else begin
        do_read(VECS[v].addr, resp, data, lat);
        chk(resp == (VECS[v].err ? 2'b10 : 2'b00), VECS[v].err ? "R4" : "R2",
            "read resp", {30'd0, resp}, {30'd0, VECS[v].err ? 2'b10 : 2'b00});
        chk(lat == exp_lat, VECS[v].err ? "R5" : "R10", "read resp cycle", lat, exp_lat);
        chk(data == (VECS[v].err ? 32'hFFFF_FFFF : rd_pat(VECS[v].addr)),
            VECS[v].err ? "R4" : "R2", "read data", data,
            VECS[v].err ? 32'hFFFF_FFFF : rd_pat(VECS[v].addr));
      end
      drain(stray);
      chk(!stray, "R7", "late response leaked to master", {31'd0, stray}, 32'd0);
    end

    // R6: error response held while master stalls bready
    acc_w = 0; lat_w = 255;
    do_write(32'h0000_0700, 32'h8888_8888, 5, resp, lat, held);
    chk(resp == 2'b10, "R6", "held write resp", {30'd0, resp}, 32'd2);
    chk(held, "R6", "bvalid/bresp stable until handshake", {31'd0, held}, 32'd1);
    chk(lat == TMO + 1, "R5", "write resp cycle, slave never ready", lat, TMO + 1);
    drain(stray);

    // R9: stalled read alongside a fast write
    acc_w = 1; lat_w = 2; acc_r = 0; lat_r = 255;
    fork
      do_write(32'h0000_0800, 32'h9999_9999, 0, resp, lat, held);
      do_read(32'h0000_0804, resp2, data, lat2);
    join
    chk(resp == 2'b00 && lat == 3, "R9", "write beside stalled read", lat, 32'd3);
    chk(resp2 == 2'b10 && data == 32'hFFFF_FFFF, "R9", "stalled read error", data, 32'hFFFF_FFFF);
    chk(lat2 == TMO + 1, "R9", "stalled read timing", lat2, TMO + 1);
    drain(stray);
    chk(!stray, "R7", "stray after parallel pair", {31'd0, stray}, 32'd0);

    // R8: fresh write after all of the above
    acc_w = 1; acc_r = 1; lat_w = 0;
    do_write(32'h0000_0900, 32'hAAAA_AAAA, 0, resp, lat, held);
    chk(resp == 2'b00 && lat == 1, "R8", "write after timeouts", lat, 32'd1);

    summary();
    $finish;
  end

endmodule